// File: doc/BRIEF.md
# Infrared Framed Serial Transmitter

This block turns a stream of bytes into one framed, bit-serial transmission for a medium-speed infrared link. A source hands it bytes over a valid/ready interface and marks the final byte of a frame. The first byte of every frame is a station address. Every later byte (control or data) is handled exactly like the address. The block wraps the bytes between opening and closing flag patterns, appends a 16-bit CRC-CCITT check value and inserts zero bits so that no flag pattern can appear inside the frame.

An external strobe, `bit_en`, sets the pace. The serial output changes only on clock edges where the strobe is high, so the line-rate divider stays outside the block. Between frames the line rests high. While a frame is on the wire, the block requests a new byte only at byte boundaries inside the payload. If the source is late at such a boundary, the frame pauses and the line holds its level until the byte arrives.

Top module: `ir_hdlc_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1 and `in_ready` is 1. A strobe with no frame in progress drives 1.
- R2: The first strobe after the first byte is accepted starts two back-to-back flag bytes of value 0x7E (bit pattern 0,1,1,1,1,1,1,0). No zero is inserted inside any flag.
- R3: Payload bytes are sent in the order they are accepted, each with bit 0 first and bit 7 last. The address byte is treated the same as the control and data bytes.
- R4: The CRC register is preset to 0xFFFF when a frame is accepted. It advances once for every payload bit in the order the bits are sent: feedback = reg[15] XOR bit, then reg is shifted left by one, then XORed with 0x1021 if the feedback is 1. Flags and inserted zeros never advance it.
- R5: Right after the last payload bit, the bitwise inverse of the final CRC register is sent as 16 bits, bit 15 first.
- R6: After five consecutive 1 bits in the payload or CRC region, a 0 is sent on the next strobe. The run count carries across byte boundaries and across the payload/CRC boundary. A run that ends the CRC is followed by its zero before the closing flag.
- R7: Exactly one 0x7E flag follows the CRC, after which the line returns to the idle level of R1.
- R8: A frame whose first byte is also marked last carries only the address byte, the CRC and the flags.
- R9: `in_ready` is 0 during the opening flags, the CRC and the closing flag. It is 1 only when idle or when the payload waits for its next byte.
- R10: `tx_line` changes only on clock edges where `bit_en` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe that advances the serial output by one bit |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte ends the frame |
| in_ready | output | 1 | Block accepts the offered byte on this edge |
| tx_line | output | 1 | Serial line output, high when idle |

## Verification
The bench sends a frame of address only, frames of 0xFF bytes in which zeros must be inserted across byte edges and into the CRC, and a run of pseudo-random frames. Each serial bit is compared against a reference stream that the bench builds from the requirements. A design that counted inserted zeros in the CRC, or cleared the run count at byte edges, would put out wrong bits at the CRC or near the boundary. A design that sent the CRC low bit first, or without inversion, would fail on the first CRC bit. The bench also watches the edges without a strobe for stray line changes, and checks that `in_ready` stays low through the flags and the CRC.

// File: rtl/ir_hdlc_pkg.sv
package ir_hdlc_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          CRC_W      = 16;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam int          RUN_MAX    = 5;
    localparam int          OPEN_FLAGS = 2;
    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_LOAD,
        ST_CRC,
        ST_CLOSE
    } tx_state_e;

    // one serial step of the check register, bit taken in send order
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic             b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/ir_tx_crc.sv
module ir_tx_crc
    import ir_hdlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             adv,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_nx
);

    always_comb crc_nx = crc_step(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst)       crc_q <= CRC_PRESET;
        else if (init) crc_q <= CRC_PRESET;
        else if (adv)  crc_q <= crc_nx;
    end

    // R4: register only moves on a payload bit or a new frame
    a_r4_crc_hold: assert property (@(posedge clk) disable iff (rst)
        (!init && !adv) |=> $stable(crc_q));

endmodule

// File: rtl/ir_tx_stuff.sv
module ir_tx_stuff #(
    parameter int RUN = ir_hdlc_pkg::RUN_MAX
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic bit_val,
    input  logic stuff_emit,
    output logic need_stuff
);

    localparam int RW = $clog2(RUN + 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || clr || stuff_emit) run_q <= '0;
        else if (step)                run_q <= bit_val ? run_q + 1'b1 : '0;
    end

    always_comb need_stuff = (run_q == RW'(RUN));

    // R6: run of ones never grows past the limit
    a_r6_run_bounded: assert property (@(posedge clk) disable iff (rst)
        run_q <= RW'(RUN));

    // R6: a pending insertion blocks any further counted bit
    a_r6_no_step_when_due: assert property (@(posedge clk) disable iff (rst)
        need_stuff |-> !step);

endmodule

// File: rtl/ir_hdlc_tx.sv
module ir_hdlc_tx
    import ir_hdlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       tx_line
);

    localparam int OPEN_BITS = OPEN_FLAGS * BYTE_W;
    localparam int CNT_MAX   = (OPEN_BITS > CRC_W) ? OPEN_BITS : CRC_W;
    localparam int CNT_W     = $clog2(CNT_MAX);

    tx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       sh;
    logic             last_q;
    logic [CRC_W-1:0] crc_sh;
    logic             tx_q;

    logic             accept, stuff_now, need_stuff;
    logic             data_go, crc_go, step, bit_val;
    logic [CRC_W-1:0] crc_q, crc_nx;

    always_comb begin
        in_ready  = (st == ST_IDLE) || (st == ST_LOAD);
        accept    = in_valid && in_ready;
        stuff_now = bit_en && need_stuff &&
                    (st == ST_DATA || st == ST_CRC || st == ST_CLOSE);
        data_go   = bit_en && !need_stuff && (st == ST_DATA);
        crc_go    = bit_en && !need_stuff && (st == ST_CRC);
        step      = data_go || crc_go;
        bit_val   = (st == ST_DATA) ? sh[0] : crc_sh[CRC_W-1];
    end

    ir_tx_crc u_crc (
        .clk    (clk),
        .rst    (rst),
        .init   (accept && st == ST_IDLE),
        .adv    (data_go),
        .din    (sh[0]),
        .crc_q  (crc_q),
        .crc_nx (crc_nx)
    );

    ir_tx_stuff #(.RUN(RUN_MAX)) u_stuff (
        .clk        (clk),
        .rst        (rst),
        .clr        (accept && st == ST_IDLE),
        .step       (step),
        .bit_val    (bit_val),
        .stuff_emit (stuff_now),
        .need_stuff (need_stuff)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            last_q <= 1'b0;
            crc_sh <= '0;
            tx_q   <= 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (bit_en) tx_q <= 1'b1;
                    if (accept) begin
                        sh     <= in_data;
                        last_q <= in_last;
                        cnt    <= '0;
                        st     <= ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (bit_en) begin
                        tx_q <= FLAG_BYTE[cnt[2:0]];
                        if (cnt == CNT_W'(OPEN_BITS - 1)) begin
                            cnt <= '0;
                            st  <= ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (stuff_now) begin
                        tx_q <= 1'b0;
                    end else if (data_go) begin
                        tx_q <= sh[0];
                        sh   <= sh >> 1;
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            cnt <= '0;
                            if (last_q) begin
                                crc_sh <= ~crc_nx;
                                st     <= ST_CRC;
                            end else begin
                                st <= ST_LOAD;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        sh     <= in_data;
                        last_q <= in_last;
                        st     <= ST_DATA;
                    end
                end
                ST_CRC: begin
                    if (stuff_now) begin
                        tx_q <= 1'b0;
                    end else if (crc_go) begin
                        tx_q   <= crc_sh[CRC_W-1];
                        crc_sh <= crc_sh << 1;
                        if (cnt == CNT_W'(CRC_W - 1)) begin
                            cnt <= '0;
                            st  <= ST_CLOSE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (stuff_now) begin
                        tx_q <= 1'b0;
                    end else if (bit_en) begin
                        tx_q <= FLAG_BYTE[cnt[2:0]];
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            cnt <= '0;
                            st  <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign tx_line = tx_q;

    // R10: the line only moves on a strobed edge
    a_r10_strobe_paced: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_en) |-> $stable(tx_line));

    // R1: an idle strobe leaves the line high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_IDLE && st == ST_IDLE && $past(bit_en)) |-> tx_line);

    // R6: an inserted bit is a zero on the line
    a_r6_stuff_zero: assert property (@(posedge clk) disable iff (rst)
        stuff_now |=> !tx_line);

    // R2: no insertion is ever pending inside the opening flags
    a_r2_open_clean: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPEN) |-> !need_stuff);

    // R5: the sixteenth check bit hands over to the closing flag
    a_r5_crc_length: assert property (@(posedge clk) disable iff (rst)
        (crc_go && cnt == CNT_W'(CRC_W - 1)) |=> (st == ST_CLOSE));

    // R9: no byte is taken while flags or check bits go out
    a_r9_busy_no_take: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPEN || st == ST_CRC || st == ST_CLOSE) |=> $stable(sh));

endmodule

// File: tb/ir_hdlc_tx_bench.sv
module ir_hdlc_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int STROBE_DIV = 4;
    localparam logic [7:0] FLAG = 8'h7E;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       tx_line;

    int n_chk = 0;
    int n_bad = 0;
    logic started = 1'b0;
    logic done = 1'b0;

    logic  q_b[$];
    logic  q_busy[$];
    string q_tag[$];

    logic [7:0] fb [0:15];
    int ones;

    ir_hdlc_tx u_ir_hdlc_tx (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .tx_line  (tx_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int div;
        div = 0;
        forever begin
            @(negedge clk);
            div = div + 1;
            bit_en = (div % STROBE_DIV == 0);
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input logic b, input logic busy, input string tag);
        q_b.push_back(b);
        q_busy.push_back(busy);
        q_tag.push_back(tag);
    endtask

    task automatic push_run(input logic b, input logic busy, input string tag);
        push(b, busy, tag);
        ones = b ? ones + 1 : 0;
        if (ones == 5) begin
            push(1'b0, busy, "R6");
            ones = 0;
        end
    endtask

    // reference stream built from the requirements
    task automatic build(input int n);
        logic [15:0] crc;
        logic        f;
        string       dtag;
        dtag = (n == 1) ? "R8" : "R3";
        for (int i = 0; i < 16; i++) push(FLAG[i % 8], 1'b1, "R2");
        crc  = 16'hFFFF;
        ones = 0;
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) begin
                f   = crc[15] ^ fb[k][i];
                crc = {crc[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
                push_run(fb[k][i], 1'b0, dtag);
            end
        end
        crc = ~crc;
        for (int i = 15; i >= 0; i--) push_run(crc[i], 1'b1, "R4 R5");
        for (int i = 0; i < 8; i++) push(FLAG[i], (i != 7), "R7");
    endtask

    task automatic send(input int n);
        forever begin
            @(negedge clk); #1;
            if (in_ready && !bit_en && q_b.size() == 0) break;
        end
        build(n);
        in_data  = fb[0];
        in_last  = (n == 1);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk); #1;
        chk("R9", in_ready, 1'b0);
        for (int k = 1; k < n; k++) begin
            in_data = fb[k];
            in_last = (k == n - 1);
            forever begin
                @(negedge clk); #1;
                if (in_ready) break;
            end
            @(posedge clk);
            @(negedge clk); #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // monitor: pops the reference stream on strobed edges
    initial begin
        logic en, prev, b, busy;
        string tag;
        wait (started);
        prev = tx_line;
        forever begin
            @(posedge clk);
            en = bit_en;
            #1;
            if (en) begin
                if (q_b.size() > 0) begin
                    b    = q_b.pop_front();
                    busy = q_busy.pop_front();
                    tag  = q_tag.pop_front();
                    chk(tag, tx_line, b);
                    if (busy) chk("R9", in_ready, 1'b0);
                end else begin
                    chk("R1", tx_line, 1'b1);
                end
            end else begin
                chk("R10", tx_line, prev);
            end
            prev = tx_line;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1", tx_line, 1'b1);
        chk("R1", in_ready, 1'b1);
        started = 1'b1;

        // R8: address only
        fb[0] = 8'hA5;
        send(1);

        // R3: mixed bytes, LSB first
        fb[0] = 8'h3C; fb[1] = 8'h00; fb[2] = 8'h81;
        send(3);

        // R6: long runs across byte and CRC edges
        fb[0] = 8'hFF; fb[1] = 8'hFF; fb[2] = 8'hFF;
        send(3);

        fb[0] = 8'h1F; fb[1] = 8'hF8; fb[2] = 8'h7E;
        send(3);

        // R4 R5: pseudo-random frames
        for (int f = 0; f < 8; f++) begin
            int n;
            n = 1 + int'($urandom % 9);
            for (int k = 0; k < n; k++) fb[k] = 8'($urandom);
            send(n);
        end

        wait (q_b.size() == 0);
        repeat (40) @(posedge clk);
        @(negedge clk); #1;
        chk("R7", tx_line, 1'b1);
        chk("R1", in_ready, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule